// File: doc/BRIEF.md
# Debug Register Scan-Chain Accessor

This block turns a simple host register request into the series of JTAG scan segments needed to reach a register of a target's on-chip debug unit. The debug unit is reached through a 38-bit data-register chain. Before each access the chain must be made current. This takes three steps: an instruction that selects a chain, a data scan carrying the chain number, and an instruction that enables internal test. The block then shifts the access fields. It does not drive TAP pins itself. Each segment goes as a command to a separate shift engine, which reports the captured bits back.

A write takes one pass over the chain. A read takes two passes. The first pass posts the register address with the direction bit cleared. The second pass shifts 32 bits out to collect the value. The block remembers which chain is currently selected, so later accesses skip the two selection steps and only reload the test instruction. When the host resets the TAP, this memory is cleared.

Host requests and shift commands both use valid/ready. A request must hold its fields stable while `req_valid` is high, until `req_ready` accepts it. `req_ready` is high only when no access is in progress. Each command is held unchanged while `cmd_ready` is low. The engine answers each accepted command with exactly one `rsp_valid` pulse. The block never has more than one command outstanding, so it always takes a response and has no response back-pressure.

Top module: `dbg_chain_access`

## Requirements
- R1: A write puts exactly 38 bits onto the debug chain across its data segments: 32 + 5 + 1.
- R2: A write, after selection, issues three data-register segments in this order: 32 write-data bits with no exit, then the 5 address bits with no exit, then one bit of value 1 with exit and return to idle. All data goes least significant bit first from bit 0 of `cmd_data`.
- R3: The first pass of a read issues the 5 address bits with no exit, then one bit of value 0 with exit and return to idle.
- R4: The second pass of a read is a 32-bit data-register segment of zeros with exit and return to idle. The `rsp_data` captured for that segment becomes `rdata`.
- R5: A full selection issues three 4-bit segments, each with exit. First, the scan-select instruction (code 2) as an instruction segment without return to idle. Second, the chain number (2) as a data segment without return to idle. Third, the internal-test instruction (code 12) as an instruction segment with return to idle.
- R6: If the debug chain is already remembered as selected, an access issues only the internal-test instruction segment before its access segments.
- R7: A pulse on `tap_rst`, or a system reset, clears the remembered chain, so the next access performs a full selection.
- R8: `done` is high for exactly one cycle per access. It rises the cycle after the final response, with `rdata` registered at that time.
- R9: `req_ready` is high only while idle. A command that is stalled by `cmd_ready` stays unchanged until it is accepted.
- R10: No new command is offered while a previous command is still awaiting its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tap_rst | input | 1 | Host TAP reset notice; clears the remembered chain |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | 5 | Debug register address |
| req_wdata | input | 32 | Write data |
| done | output | 1 | Single-cycle access completion |
| rdata | output | 32 | Read value, valid with `done` for reads |
| cmd_valid | output | 1 | Shift command valid |
| cmd_ready | input | 1 | Shift engine accepts command |
| cmd_ir | output | 1 | 1 = instruction scan, 0 = data scan |
| cmd_len | output | 6 | Number of bits to shift (1..32) |
| cmd_data | output | 32 | Bits to shift, bit 0 first |
| cmd_exit | output | 1 | Leave the shift state after the last bit |
| cmd_idle | output | 1 | After update, go to Run-Test/Idle instead of straight to Select-DR |
| rsp_valid | input | 1 | Shift engine result pulse |
| rsp_data | input | 32 | Bits captured during the segment, first bit at bit 0 |

## Verification
The properties assume that the shift engine returns exactly one `rsp_valid` pulse per accepted command, and never one without a command outstanding. They also assume that the host holds request fields while `req_valid` is high. The bench engine model follows both rules: it answers a fixed three cycles after acceptance. It also stalls `cmd_ready` in a repeating pattern so the hold rule is exercised. The host tasks raise `req_valid` only while `req_ready` is seen high, and drop it after one cycle.

// File: rtl/dbg_chain_pkg.sv
package dbg_chain_pkg;

  typedef enum logic [3:0] {
    STEP_IDLE,
    STEP_SEL_IR,
    STEP_SEL_NUM,
    STEP_TEST_IR,
    STEP_W_DATA,
    STEP_W_ADDR,
    STEP_W_RW,
    STEP_R_ADDR,
    STEP_R_RW,
    STEP_R_DATA
  } step_e;

  // Ordering of segments within one access; final steps return to idle elsewhere.
  function automatic step_e step_after(step_e s, logic wr);
    case (s)
      STEP_SEL_IR:  return STEP_SEL_NUM;
      STEP_SEL_NUM: return STEP_TEST_IR;
      STEP_TEST_IR: return wr ? STEP_W_DATA : STEP_R_ADDR;
      STEP_W_DATA:  return STEP_W_ADDR;
      STEP_W_ADDR:  return STEP_W_RW;
      STEP_R_ADDR:  return STEP_R_RW;
      STEP_R_RW:    return STEP_R_DATA;
      default:      return STEP_IDLE;
    endcase
  endfunction

  function automatic logic is_final(step_e s);
    return (s == STEP_W_RW) || (s == STEP_R_DATA);
  endfunction

endpackage

// File: rtl/dbg_chain_track.sv
module dbg_chain_track #(
  parameter int unsigned IR_W     = 4,
  parameter int unsigned CHAIN_ID = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic forget,
  input  logic sel_done,
  output logic selected
);
  logic            valid_q;
  logic [IR_W-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      chain_q <= '0;
    end else if (forget) begin
      valid_q <= 1'b0;
    end else if (sel_done) begin
      valid_q <= 1'b1;
      chain_q <= IR_W'(CHAIN_ID);
    end
  end

  assign selected = valid_q && (chain_q == IR_W'(CHAIN_ID));
endmodule

// File: rtl/dbg_chain_seq.sv
module dbg_chain_seq
  import dbg_chain_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              selected,
  input  logic              cmd_ready,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              req_ready,
  output logic              accept,
  output step_e             step,
  output logic              wr,
  output logic              cmd_valid,
  output logic              sel_done,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  step_e step_q;
  logic  wait_q;
  logic  wr_q;
  logic  issue;
  logic  finish;

  assign req_ready = (step_q == STEP_IDLE);
  assign accept    = req_valid && req_ready;
  assign cmd_valid = (step_q != STEP_IDLE) && !wait_q;
  assign issue     = cmd_valid && cmd_ready;
  assign finish    = wait_q && rsp_valid;
  assign sel_done  = finish && (step_q == STEP_SEL_NUM);
  assign step      = step_q;
  assign wr        = wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= STEP_IDLE;
      wait_q <= 1'b0;
      wr_q   <= 1'b0;
      done   <= 1'b0;
      rdata  <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        wr_q   <= req_write;
        step_q <= selected ? STEP_TEST_IR : STEP_SEL_IR;
      end
      if (issue) wait_q <= 1'b1;
      if (finish) begin
        wait_q <= 1'b0;
        if (is_final(step_q)) begin
          done   <= 1'b1;
          rdata  <= rsp_data;
          step_q <= STEP_IDLE;
        end else begin
          step_q <= step_after(step_q, wr_q);
        end
      end
    end
  end
endmodule

// File: rtl/dbg_chain_encode.sv
module dbg_chain_encode
  import dbg_chain_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned IR_W        = 4,
  parameter int unsigned CHAIN_ID    = 2,
  parameter int unsigned IR_SCAN_SEL = 2,
  parameter int unsigned IR_TEST     = 12,
  localparam int unsigned LEN_W      = $clog2(DATA_W + 1)
) (
  input  step_e             step,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              cmd_ir,
  output logic [LEN_W-1:0]  cmd_len,
  output logic [DATA_W-1:0] cmd_data,
  output logic              cmd_exit,
  output logic              cmd_idle
);
  always_comb begin
    cmd_ir   = 1'b0;
    cmd_len  = '0;
    cmd_data = '0;
    cmd_exit = 1'b1;
    cmd_idle = 1'b0;
    case (step)
      STEP_SEL_IR: begin
        cmd_ir   = 1'b1;
        cmd_len  = LEN_W'(IR_W);
        cmd_data = DATA_W'(IR_SCAN_SEL);
      end
      STEP_SEL_NUM: begin
        cmd_len  = LEN_W'(IR_W);
        cmd_data = DATA_W'(CHAIN_ID);
      end
      STEP_TEST_IR: begin
        cmd_ir   = 1'b1;
        cmd_len  = LEN_W'(IR_W);
        cmd_data = DATA_W'(IR_TEST);
        cmd_idle = 1'b1;
      end
      STEP_W_DATA: begin
        cmd_len  = LEN_W'(DATA_W);
        cmd_data = wdata;
        cmd_exit = 1'b0;
      end
      STEP_W_ADDR, STEP_R_ADDR: begin
        cmd_len  = LEN_W'(ADDR_W);
        cmd_data = DATA_W'(addr);
        cmd_exit = 1'b0;
      end
      STEP_W_RW: begin
        cmd_len  = LEN_W'(1);
        cmd_data = DATA_W'(1);
        cmd_idle = 1'b1;
      end
      STEP_R_RW: begin
        cmd_len  = LEN_W'(1);
        cmd_idle = 1'b1;
      end
      STEP_R_DATA: begin
        cmd_len  = LEN_W'(DATA_W);
        cmd_idle = 1'b1;
      end
      default: cmd_exit = 1'b0;
    endcase
  end
endmodule

// File: rtl/dbg_chain_access.sv
module dbg_chain_access
  import dbg_chain_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned IR_W        = 4,
  parameter int unsigned CHAIN_ID    = 2,
  parameter int unsigned IR_SCAN_SEL = 2,
  parameter int unsigned IR_TEST     = 12,
  localparam int unsigned LEN_W      = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tap_rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_ir,
  output logic [LEN_W-1:0]  cmd_len,
  output logic [DATA_W-1:0] cmd_data,
  output logic              cmd_exit,
  output logic              cmd_idle,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data
);
  step_e             step;
  logic              accept;
  logic              wr;
  logic              selected;
  logic              sel_done;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  dbg_chain_track #(.IR_W(IR_W), .CHAIN_ID(CHAIN_ID)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .forget   (tap_rst),
    .sel_done (sel_done),
    .selected (selected)
  );

  dbg_chain_seq #(.DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .selected  (selected),
    .cmd_ready (cmd_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .req_ready (req_ready),
    .accept    (accept),
    .step      (step),
    .wr        (wr),
    .cmd_valid (cmd_valid),
    .sel_done  (sel_done),
    .done      (done),
    .rdata     (rdata)
  );

  dbg_chain_encode #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IR_W(IR_W), .CHAIN_ID(CHAIN_ID),
    .IR_SCAN_SEL(IR_SCAN_SEL), .IR_TEST(IR_TEST)
  ) u_enc (
    .step     (step),
    .addr     (addr_q),
    .wdata    (wdata_q),
    .cmd_ir   (cmd_ir),
    .cmd_len  (cmd_len),
    .cmd_data (cmd_data),
    .cmd_exit (cmd_exit),
    .cmd_idle (cmd_idle)
  );

  logic unused_wr;
  assign unused_wr = wr;
endmodule

// File: rtl/dbg_chain_access_chk.sv
module dbg_chain_access_chk #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned IR_W        = 4,
  parameter int unsigned IR_SCAN_SEL = 2,
  localparam int unsigned LEN_W      = $clog2(DATA_W + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              done,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_ir,
  input logic [LEN_W-1:0]  cmd_len,
  input logic [DATA_W-1:0] cmd_data,
  input logic              cmd_exit,
  input logic              cmd_idle,
  input logic              rsp_valid
);
  logic out_q;
  always_ff @(posedge clk) begin
    if (!rst_n) out_q <= 1'b0;
    else if (cmd_valid && cmd_ready) out_q <= 1'b1;
    else if (rsp_valid) out_q <= 1'b0;
  end

  a_r9_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_data) && $stable(cmd_len) && $stable(cmd_ir));

  a_r9_ready_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !cmd_valid);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(rsp_valid));

  a_r5_ir_shape: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ir |-> cmd_len == LEN_W'(IR_W) && cmd_exit);

  a_r5_select_stays_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ir && cmd_data == DATA_W'(IR_SCAN_SEL) |-> !cmd_idle);

  a_r2_open_segment: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_exit |-> !cmd_ir && (cmd_len == LEN_W'(DATA_W) || cmd_len == LEN_W'(ADDR_W)));

  a_r10_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    out_q && !rsp_valid |-> !cmd_valid);
endmodule

bind dbg_chain_access dbg_chain_access_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IR_W(IR_W), .IR_SCAN_SEL(IR_SCAN_SEL)
) i_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_ir(cmd_ir),
  .cmd_len(cmd_len), .cmd_data(cmd_data), .cmd_exit(cmd_exit),
  .cmd_idle(cmd_idle), .rsp_valid(rsp_valid)
);

// File: tb/test_dbg_chain_access.sv
module test_dbg_chain_access;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tap_rst = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        done;
  logic [31:0] rdata;
  logic        cmd_valid;
  logic        cmd_ready;
  logic        cmd_ir;
  logic [5:0]  cmd_len;
  logic [31:0] cmd_data;
  logic        cmd_exit;
  logic        cmd_idle;
  logic        rsp_valid;
  logic [31:0] rsp_data;

  always #4 clk = ~clk;

  dbg_chain_access i_dbg_chain_access (.*);

  int checks = 0;
  int errors = 0;
  logic [31:0] key = '0;

  // shift engine model with stall pattern and 3-cycle answer latency
  logic        log_ir [128];
  logic [5:0]  log_len [128];
  logic [31:0] log_data [128];
  logic        log_exit [128];
  logic        log_idle [128];
  int          log_n;
  int          ovl_err, hold_err;
  logic [2:0]  rcnt;
  logic        pend;
  logic [1:0]  lat;
  logic [31:0] pend_data;
  logic        prev_stall;
  logic [31:0] prev_data;

  assign cmd_ready = (rcnt != 3'd1) && (rcnt != 3'd2);

  always @(posedge clk) begin
    if (!rst_n) begin
      rcnt <= '0; pend <= 1'b0; lat <= '0; rsp_valid <= 1'b0; rsp_data <= '0;
      prev_stall <= 1'b0; prev_data <= '0;
      if (log_n > 1000) log_n <= 0;
    end else begin
      rcnt <= rcnt + 3'd1;
      rsp_valid <= 1'b0;
      prev_stall <= cmd_valid && !cmd_ready;
      prev_data  <= cmd_data;
      if (prev_stall && (!cmd_valid || cmd_data != prev_data)) hold_err <= hold_err + 1;
      if (cmd_valid && cmd_ready) begin
        if (pend) ovl_err <= ovl_err + 1;
        log_ir[log_n % 128]   <= cmd_ir;
        log_len[log_n % 128]  <= cmd_len;
        log_data[log_n % 128] <= cmd_data;
        log_exit[log_n % 128] <= cmd_exit;
        log_idle[log_n % 128] <= cmd_idle;
        log_n <= log_n + 1;
        pend <= 1'b1; lat <= 2'd2; pend_data <= cmd_data ^ key;
      end else if (pend) begin
        if (lat == 2'd0) begin
          rsp_valid <= 1'b1; rsp_data <= pend_data; pend <= 1'b0;
        end else lat <= lat - 2'd1;
      end
    end
  end

  initial begin log_n = 0; ovl_err = 0; hold_err = 0; end

  task automatic check(input string tag, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic seg(input string tag, input int idx, input logic ir, input int len,
                     input logic [31:0] dat, input logic ex, input logic idl);
    bit ok;
    ok = (log_ir[idx] == ir) && (log_len[idx] == 6'(len)) && (log_data[idx] == dat) &&
         (log_exit[idx] == ex) && (log_idle[idx] == idl);
    check(tag, ok, {log_ir[idx], log_exit[idx], log_idle[idx], 3'b0, log_len[idx], 20'(log_data[idx])},
          {ir, ex, idl, 3'b0, 6'(len), 20'(dat)});
  endtask

  bit sel_known = 1'b0;

  task automatic pulse_tap_rst();
    @(negedge clk); tap_rst = 1'b1;
    @(negedge clk); tap_rst = 1'b0;
    sel_known = 1'b0;
  endtask

  task automatic access(input logic wr, input logic [4:0] a, input logic [31:0] wd, input logic [31:0] k);
    int base, n, guard, exp_n, width;
    key = k;
    @(negedge clk);
    guard = 0;
    while (!req_ready && guard < 500) begin @(negedge clk); guard++; end
    base = log_n;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!done && guard < 500) begin @(negedge clk); guard++; end
    check("R8 done seen", done === 1'b1, 32'(done), 32'd1);
    if (!wr) check("R4 read data", rdata == k, rdata, k);
    @(negedge clk);
    width = 0;
    check("R8 done single cycle", done == 1'b0, 32'(done), 32'd0);
    exp_n = (sel_known ? 1 : 3) + 3;
    n = log_n - base;
    check(sel_known ? "R6 segment count" : "R5 segment count", n == exp_n, 32'(n), 32'(exp_n));
    if (n == exp_n) begin
      if (!sel_known) begin
        seg("R5 scan-select instr", base, 1, 4, 32'd2, 1, 0);
        seg("R5 chain number", base + 1, 0, 4, 32'd2, 1, 0);
        base += 2;
      end
      seg(sel_known ? "R6 test instr only" : "R5 test instr", base, 1, 4, 32'd12, 1, 1);
      if (wr) begin
        seg("R2 write data", base + 1, 0, 32, wd, 0, 0);
        seg("R2 write addr", base + 2, 0, 5, 32'(a), 0, 0);
        seg("R2 write flag", base + 3, 0, 1, 32'd1, 1, 1);
        for (int i = 1; i <= 3; i++) width += int'(log_len[base + i]);
        check("R1 chain length", width == 38, 32'(width), 32'd38);
      end else begin
        seg("R3 read addr", base + 1, 0, 5, 32'(a), 0, 0);
        seg("R3 read flag", base + 2, 0, 1, 32'd0, 1, 1);
        seg("R4 read out pass", base + 3, 0, 32, 32'd0, 1, 1);
      end
    end
    sel_known = 1'b1;
  endtask

  // {tap_rst_before, write, addr, wdata, key}
  localparam logic [70:0] VECS [6] = '{
    {1'b0, 1'b1, 5'h08, 32'h0000_0100, 32'h0000_0000},
    {1'b0, 1'b0, 5'h01, 32'h0000_0000, 32'h1234_5678},
    {1'b0, 1'b1, 5'h1F, 32'hFFFF_FFFF, 32'h0F0F_0F0F},
    {1'b1, 1'b0, 5'h00, 32'h0000_0000, 32'hDEAD_BEEF},
    {1'b0, 1'b0, 5'h1F, 32'h0000_0000, 32'h8000_0001},
    {1'b1, 1'b1, 5'h0A, 32'hA5A5_5A5A, 32'h0000_0000}
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset ready", req_ready == 1'b1, 32'(req_ready), 32'd1);
    check("R10 reset no command", cmd_valid == 1'b0, 32'(cmd_valid), 32'd0);
    check("R8 reset no done", done == 1'b0, 32'(done), 32'd0);

    for (int v = 0; v < 6; v++) begin
      if (VECS[v][70]) pulse_tap_rst();   // R7
      access(VECS[v][69], VECS[v][68:64], VECS[v][63:32], VECS[v][31:0]);
    end

    // R7: system reset forgets the selected chain too
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    sel_known = 1'b0;
    access(1'b0, 5'h15, 32'h0, 32'h5555_AAAA);
    // R6: back-to-back read after that skips selection
    access(1'b0, 5'h02, 32'h0, 32'hCAFE_F00D);
    // R7: two TAP resets in a row still need only one full selection
    pulse_tap_rst();
    pulse_tap_rst();
    access(1'b1, 5'h11, 32'h8000_0000, 32'h0);

    check("R10 one command outstanding", ovl_err == 0, 32'(ovl_err), 32'd0);
    check("R9 command held under stall", hold_err == 0, 32'(hold_err), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule